// File: doc/BRIEF.md
# Key-protected system control register

This block is a single 32-bit control word on a simple memory-mapped bus. The bus has an address, a write strobe with write data, and a read strobe with read data. The word holds a 3-bit priority grouping value that is driven out to the interrupt logic. It also reports a fixed data-endianness flag and lets software ask the outside system for a reset.

Every write is guarded by a 16-bit unlock key in the upper half of the write data. If the key is wrong, the whole write is thrown away, and that includes the reset-request bit. When the upper half is read back, it returns a status constant instead of the key.

A keyed write with the reset bit set starts a small handshake machine with three states:
- `RR_IDLE` is the quiet state.
- Transition *launch* (a keyed write with the reset bit set) moves to `RR_ASSERT`, which drives the request output.
- Transition *grant* (the acknowledge input is seen high) moves to `RR_DRAIN`, which drops the request.
- Transition *settle* (the acknowledge input is low) returns to `RR_IDLE`.

A request write that arrives outside `RR_IDLE` has no further effect. The two debug bits do nothing, but a keyed write that sets either of them raises a one-cycle debug-error pulse.

Top module: `sysctl_keyreg`

## Requirements
- R1: After reset, grp_o is 3'b000, rst_req_o is 0, dbg_err_o is 0 and bus_rdata is 0.
- R2: A write to REG_ADDR whose bits [31:16] equal KEY (default 16'h05FA) loads bits [10:8] into the grouping value, which is seen on grp_o from the next cycle.
- R3: A write whose bits [31:16] differ from KEY changes nothing: grp_o keeps its value, and neither rst_req_o nor dbg_err_o asserts.
- R4: A read of REG_ADDR returns, one cycle later, STAT (default 16'hFA05) in [31:16], ENDIAN_BIG in bit 15, and the grouping value in [10:8]. Bits [14:11], [7:3], 1 and 0 read as 0. In cycles that carry no read of REG_ADDR, bus_rdata is 0.
- R5: A keyed write with bit 2 set, made in state RR_IDLE, asserts rst_req_o from the next cycle.
- R6: rst_req_o stays high while rst_ack_i is low. It falls in the cycle after rst_ack_i is seen high, and the machine returns to idle once rst_ack_i is low.
- R7: A keyed write with bit 1 or bit 0 set still updates the grouping value, and it pulses dbg_err_o high for exactly the next cycle.
- R8: A write to any address other than REG_ADDR, even with the correct key, changes nothing.
- R9: Bit 2 reads as 0, even while a reset request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data, key in [31:16] |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| grp_o | output | 3 | Priority grouping value |
| rst_req_o | output | 1 | System reset request |
| rst_ack_i | input | 1 | Reset request acknowledge |
| dbg_err_o | output | 1 | Pulse: debug bits written as 1 |

## Verification
Each result comes one clock after the edge that samples the stimulus:
- the grouping value and the debug-error pulse come from registers in the write path;
- the read data comes from a register in the read path;
- the reset request is decoded from the handshake state, which changes on that same edge.

The bench notes the cycle number at which it drives a stimulus. It then queues each expected output under that number plus one. A monitor running on the falling edge compares the queue entries exactly in their cycle, so a result that comes a cycle early or a cycle late counts as a mismatch.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned HALF_W  = 16;
    localparam int unsigned GRP_W   = 3;
    localparam int unsigned GRP_LSB = 8;
    localparam int unsigned END_BIT = 15;
    localparam int unsigned REQ_BIT = 2;
    localparam int unsigned DBG_W   = 2;

    typedef enum logic [1:0] {
        RR_IDLE   = 2'd0,
        RR_ASSERT = 2'd1,
        RR_DRAIN  = 2'd2
    } rr_state_e;

endpackage

// File: rtl/sysctl_wr_decode.sv
module sysctl_wr_decode
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0,
    parameter logic [HALF_W-1:0] KEY = 16'h05FA
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 we,
    input  logic [WORD_W-1:0]    wdata,
    output logic [GRP_W-1:0]     grp_q,
    output logic                 req_launch,
    output logic                 dbg_err_q
);

    logic hit;
    logic key_ok;
    logic keyed_wr;
    logic dbg_any;

    assign hit        = (addr == REG_ADDR);
    assign key_ok     = (wdata[WORD_W-1 -: HALF_W] == KEY);
    assign keyed_wr   = we && hit && key_ok;
    assign dbg_any    = |wdata[DBG_W-1:0];
    assign req_launch = keyed_wr && wdata[REQ_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp_q     <= '0;
            dbg_err_q <= 1'b0;
        end else begin
            dbg_err_q <= keyed_wr && dbg_any;
            if (keyed_wr) begin
                grp_q <= wdata[GRP_LSB +: GRP_W];
            end
        end
    end

    p_badkey_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !key_ok) |=> $stable(grp_q));

    p_wrong_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !hit) |=> $stable(grp_q));

    p_err_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dbg_err_q) |-> $past(we && hit && key_ok));

endmodule

// File: rtl/sysctl_rst_fsm.sv
module sysctl_rst_fsm
    import sysctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic ack,
    output logic req
);

    rr_state_e state_q;
    rr_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RR_IDLE:   if (launch) state_d = RR_ASSERT;
            RR_ASSERT: if (ack)    state_d = RR_DRAIN;
            RR_DRAIN:  if (!ack)   state_d = RR_IDLE;
            default:               state_d = RR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        req = 1'b0;
        unique case (state_q)
            RR_IDLE:   req = 1'b0;
            RR_ASSERT: req = 1'b1;
            RR_DRAIN:  req = 1'b0;
            default:   req = 1'b0;
        endcase
    end

    p_req_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> $past(launch));

    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> req);

    p_req_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack) |=> !req);

endmodule

// File: rtl/sysctl_rd_mux.sv
module sysctl_rd_mux
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0,
    parameter logic [HALF_W-1:0] STAT = 16'hFA05,
    parameter bit ENDIAN_BIG = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 re,
    input  logic [GRP_W-1:0]     grp,
    output logic [WORD_W-1:0]    rdata
);

    logic [WORD_W-1:0] word;

    always_comb begin
        word                          = '0;
        word[WORD_W-1 -: HALF_W]      = STAT;
        word[END_BIT]                 = ENDIAN_BIG;
        word[GRP_LSB +: GRP_W]        = grp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re && (addr == REG_ADDR)) begin
            rdata <= word;
        end else begin
            rdata <= '0;
        end
    end

    p_read_grp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (re && addr == REG_ADDR) |=> (rdata[GRP_LSB +: GRP_W] == $past(grp)));

    p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(re && addr == REG_ADDR) |=> (rdata == '0));

    p_req_bit_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[REQ_BIT] == 1'b0);

endmodule

// File: rtl/sysctl_keyreg.sv
module sysctl_keyreg
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h0C,
    parameter logic [15:0] KEY  = 16'h05FA,
    parameter logic [15:0] STAT = 16'hFA05,
    parameter bit ENDIAN_BIG = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_re,
    output logic [31:0]       bus_rdata,
    output logic [2:0]        grp_o,
    output logic              rst_req_o,
    input  logic              rst_ack_i,
    output logic              dbg_err_o
);

    logic [GRP_W-1:0] grp_w;
    logic             launch_w;

    sysctl_wr_decode #(
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR),
        .KEY      (KEY)
    ) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (bus_addr),
        .we         (bus_we),
        .wdata      (bus_wdata),
        .grp_q      (grp_w),
        .req_launch (launch_w),
        .dbg_err_q  (dbg_err_o)
    );

    sysctl_rst_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (launch_w),
        .ack    (rst_ack_i),
        .req    (rst_req_o)
    );

    sysctl_rd_mux #(
        .ADDR_W     (ADDR_W),
        .REG_ADDR   (REG_ADDR),
        .STAT       (STAT),
        .ENDIAN_BIG (ENDIAN_BIG)
    ) u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr),
        .re    (bus_re),
        .grp   (grp_w),
        .rdata (bus_rdata)
    );

    assign grp_o = grp_w;

endmodule

// File: tb/tb_sysctl_keyreg.sv
`timescale 1ns/1ps
module tb_sysctl_keyreg;

    localparam logic [7:0] RA = 8'h0C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic [2:0]  grp_o;
    logic        rst_req_o;
    logic        rst_ack_i = 1'b0;
    logic        dbg_err_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cnt = 0;
    bit done = 1'b0;

    typedef struct {
        int          cyc;
        int          sel;
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t q[$];

    sysctl_keyreg dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .grp_o(grp_o), .rst_req_o(rst_req_o), .rst_ack_i(rst_ack_i),
        .dbg_err_o(dbg_err_o)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cnt <= cnt + 1;

    function automatic logic [31:0] observe(input int sel);
        case (sel)
            0:       return bus_rdata;
            1:       return {29'd0, grp_o};
            2:       return {31'd0, rst_req_o};
            default: return {31'd0, dbg_err_o};
        endcase
    endfunction

    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc <= cnt) begin
            exp_t e;
            logic [31:0] act;
            e = q.pop_front();
            act = observe(e.sel);
            n_cmp++;
            if (act !== e.exp) begin
                n_bad++;
                $display("FAIL %s cyc %0d sel %0d: actual %h expected %h",
                         e.tag, cnt, e.sel, act, e.exp);
            end
        end
    end

    task automatic drive(input logic [7:0] a, input logic we, input logic [31:0] wd,
                         input logic re, input logic ack);
        @(negedge clk);
        bus_addr = a; bus_we = we; bus_wdata = wd; bus_re = re; rst_ack_i = ack;
    endtask

    task automatic expect_next(input int sel, input logic [31:0] v, input string tag);
        exp_t e;
        e.cyc = cnt + 1; e.sel = sel; e.exp = v; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle();
        drive(RA, 1'b0, 32'd0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        idle();
        expect_next(1, 32'd0, "R1 grp");
        expect_next(2, 32'd0, "R1 req");
        expect_next(3, 32'd0, "R1 err");
        expect_next(0, 32'd0, "R1 rdata");
        // R4: read after reset
        drive(RA, 1'b0, 32'd0, 1'b1, 1'b0);
        expect_next(0, 32'hFA05_0000, "R4 read reset");
        // R2: keyed write grp=5
        drive(RA, 1'b1, 32'h05FA_0500, 1'b0, 1'b0);
        expect_next(1, 32'd5, "R2 grp load");
        expect_next(2, 32'd0, "R2 no req");
        expect_next(3, 32'd0, "R2 no err");
        drive(RA, 1'b0, 32'd0, 1'b1, 1'b0);
        expect_next(0, 32'hFA05_0500, "R4 read grp5");
        idle();
        expect_next(0, 32'd0, "R4 no read zero");
        // R3: wrong key with grp=7, reset bit and debug bit
        drive(RA, 1'b1, 32'h1234_0705, 1'b0, 1'b0);
        expect_next(1, 32'd5, "R3 grp kept");
        expect_next(2, 32'd0, "R3 no req");
        expect_next(3, 32'd0, "R3 no err");
        // R8: keyed write to another address
        drive(8'h10, 1'b1, 32'h05FA_0304, 1'b0, 1'b0);
        expect_next(1, 32'd5, "R8 grp kept");
        expect_next(2, 32'd0, "R8 no req");
        // R5: reset request launch, grp=2
        drive(RA, 1'b1, 32'h05FA_0204, 1'b0, 1'b0);
        expect_next(1, 32'd2, "R2 grp2");
        expect_next(2, 32'd1, "R5 req up");
        // R9: bit 2 reads 0 while pending
        drive(RA, 1'b0, 32'd0, 1'b1, 1'b0);
        expect_next(0, 32'hFA05_0200, "R9 read pending");
        expect_next(2, 32'd1, "R6 req held");
        for (int i = 0; i < 3; i++) begin
            idle();
            expect_next(2, 32'd1, "R6 req held idle");
        end
        // R6: acknowledge
        drive(RA, 1'b0, 32'd0, 1'b0, 1'b1);
        expect_next(2, 32'd0, "R6 req released");
        drive(RA, 1'b0, 32'd0, 1'b0, 1'b1);
        expect_next(2, 32'd0, "R6 drain low");
        idle();
        expect_next(2, 32'd0, "R6 back idle");
        // R5: a second request after returning to idle
        drive(RA, 1'b1, 32'h05FA_0204, 1'b0, 1'b0);
        expect_next(2, 32'd1, "R5 second req");
        drive(RA, 1'b0, 32'd0, 1'b0, 1'b1);
        expect_next(2, 32'd0, "R6 second release");
        idle();
        // R7: debug bits with grp=6
        drive(RA, 1'b1, 32'h05FA_0603, 1'b0, 1'b0);
        expect_next(1, 32'd6, "R7 grp updated");
        expect_next(3, 32'd1, "R7 err pulse");
        idle();
        expect_next(3, 32'd0, "R7 err one cycle");
        drive(RA, 1'b1, 32'h05FA_0001, 1'b0, 1'b0);
        expect_next(1, 32'd0, "R7 grp zero");
        expect_next(3, 32'd1, "R7 err bit0");
        drive(RA, 1'b0, 32'd0, 1'b1, 1'b0);
        expect_next(3, 32'd0, "R7 err cleared");
        expect_next(0, 32'hFA05_0000, "R4 read grp0");
        repeat (3) idle();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule